// File: doc/BRIEF.md
# Zone-Protected Software-Loaded TLB

This block is a fully associative translation lookaside buffer for a 32-bit embedded core whose page tables are managed entirely by software. Software writes entries through a dedicated write port: each entry carries a valid flag, a page-size exponent, an effective page number, a process ID, a real page number, execute and write permission bits and a 4-bit zone number. Every entry is compared in parallel against a lookup request. The request carries an effective address, a store flag, an instruction-fetch flag, the user/supervisor mode and the current machine-state word.

Access rights come from two sources. The first is the permission bits of the entry. The second is a 32-bit zone protection word that holds one 2-bit field per zone. The zone field can grant everything, defer to the entry bits, or deny user-mode access. The winning entry is the lowest-indexed entry that grants the access. The block returns one registered response per request: hit flag, entry index, real address, granted permissions and fault class. On a miss it also returns the fault address, a syndrome, an exception vector and the saved machine state.

Top module: `zone_tlb`

## Requirements
- R1: After reset, rsp_valid is 0 and every entry is invalid, so any lookup reports a miss (rsp_fault = 2).
- R2: A request accepted with req_valid=1 at a clock edge produces rsp_valid=1 for exactly the following cycle. No response appears without a request.
- R3: An entry matches only when it is valid and (address AND mask) equals its effective page number, where mask = NOT((1 << page_shift) − 1). A software write is visible to lookups from the cycle after the write edge; a lookup in the same cycle as the write sees the old contents.
- R4: An entry whose process ID is 0 matches any process. Any other ID must equal cur_pid.
- R5: On a hit, rsp_raddr = (real page number AND mask) OR (address AND NOT mask).
- R6: The zone field of zone z is zone_prot[31−2z : 30−2z], so zone 0 sits in bits [31:30]. Field value 3 grants any access with permissions read+write (rsp_perm = 2'b11), whatever the entry bits say.
- R7: Field value 0 denies every user-mode access. In supervisor mode, field value 0 behaves like values 1 and 2.
- R8: Under field values 1 and 2, a fetch needs the execute bit and a data store needs the write bit; loads are always allowed. Granted permissions are rsp_perm = 2'b11 (bit 1 write, bit 0 read) when the write bit is set, else 2'b01.
- R9: The lowest-indexed granting entry wins and its index is returned; a matching entry that denies does not stop the search. With no granting entry, rsp_hit=0 and rsp_perm=0. rsp_fault is 0 on a hit, 1 (protection) if some entry matched, and 2 (miss) if none matched.
- R10: On a miss, rsp_dear = request address. rsp_syndrome = 0x00800000 for a data store and 0 for a data load or a fetch. rsp_vector = ITLB_VECTOR (default 0x1200) for a fetch and DTLB_VECTOR (default 0x1100) for data. When there is no miss, all three are 0.
- R11: rsp_msr equals req_msr with bits [31:16] cleared on a miss, and equals req_msr unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_valid | input | 1 | Valid flag of the loaded entry |
| wr_shift | input | 5 | Page-size exponent (page = 2^shift bytes) |
| wr_epn | input | 32 | Effective page number (aligned address) |
| wr_pid | input | 8 | Process ID, 0 = global |
| wr_rpn | input | 32 | Real page number (aligned address) |
| wr_exec | input | 1 | Execute permission |
| wr_write | input | 1 | Write permission |
| wr_zone | input | 4 | Zone number |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Zone protection word, 2 bits per zone |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address |
| req_store | input | 1 | Data store (ignored for fetches) |
| req_fetch | input | 1 | Instruction fetch |
| req_user | input | 1 | User mode |
| req_msr | input | 32 | Machine state to be saved |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Access granted |
| rsp_idx | output | 6 | Winning entry index |
| rsp_raddr | output | 32 | Real address |
| rsp_perm | output | 2 | Granted permissions, bit1 write, bit0 read |
| rsp_fault | output | 2 | 0 none, 1 protection, 2 miss |
| rsp_dear | output | 32 | Fault address on a miss |
| rsp_syndrome | output | 32 | Syndrome on a miss |
| rsp_vector | output | 32 | Exception vector on a miss |
| rsp_msr | output | 32 | Saved machine state |

## Verification
The assertions check on every cycle that the response handshake follows requests one-for-one. They also check that a hit never carries a fault and always includes read permission, and that a non-hit grants nothing. On misses they check the fault address, the fetch/data vector choice, the zero fetch syndrome and the cleared upper half of the machine state. Only the bench scenarios can show the translation itself: page-size masking, process-ID and zone decoding, first-granter ordering across overlapping entries, and the write-versus-lookup timing. These need known table contents to predict the results.

// File: rtl/zone_tlb_pkg.sv
// Shared types and helpers for the zone-protected TLB.
// Assumes 32-bit effective and real addresses.
package zone_tlb_pkg;
    localparam int ADDR_W    = 32;
    localparam int TLB_PID_W = 8;
    localparam int SHIFT_W   = 5;
    localparam int ZONE_W    = 4;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_MISS = 2'd2
    } fault_e;

    typedef struct packed {
        logic                 valid;
        logic [SHIFT_W-1:0]   shift;
        logic [ADDR_W-1:0]    epn;
        logic [TLB_PID_W-1:0] pid;
        logic [ADDR_W-1:0]    rpn;
        logic                 exec;
        logic                 write;
        logic [ZONE_W-1:0]    zone;
    } tlb_entry_t;

    // Mask keeping the page-number bits for a 2^shift page.
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SHIFT_W-1:0] s);
        return ~((ADDR_W'(1) << s) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/tlb_entry_file.sv
// Register file holding every TLB entry; one entry written per cycle.
// Assumes wr_idx < ENTRIES. Reset clears all entries (valid = 0).
module tlb_entry_file
    import zone_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_entry_t               wr_entry,
    output tlb_entry_t [ENTRIES-1:0] entries
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Store entry g when software addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entries[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                entries[g] <= wr_entry;
        end
    end
endmodule

// File: rtl/tlb_entry_check.sv
// Per-entry comparator: address/PID match plus zone and permission decision.
// Purely combinational; perm is meaningful only when granted is set.
module tlb_entry_check
    import zone_tlb_pkg::*;
(
    input  tlb_entry_t            entry,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [TLB_PID_W-1:0]  cur_pid,
    input  logic [ADDR_W-1:0]     zone_prot,
    input  logic                  store,
    input  logic                  fetch,
    input  logic                  user,
    output logic                  matched,
    output logic                  granted,
    output logic [1:0]            perm
);
    logic [4:0] zsh;
    logic [1:0] zfield;
    logic       ok;

    // Locate this entry's 2-bit field; zone 0 lives at the top.
    always_comb begin
        zsh    = 5'(6'd30 - {1'b0, entry.zone, 1'b0});
        zfield = zone_prot[zsh +: 2];
    end

    // Decide match and access rights for this entry.
    always_comb begin
        matched = entry.valid
               && (entry.pid == '0 || entry.pid == cur_pid)
               && ((addr & page_mask(entry.shift)) == entry.epn);
        perm = entry.write ? 2'b11 : 2'b01;
        ok   = 1'b0;
        if (zfield == 2'd3) begin
            ok   = 1'b1;
            perm = 2'b11;
        end else if (zfield == 2'd0 && user) begin
            ok = 1'b0;
        end else if (fetch) begin
            ok = entry.exec;
        end else begin
            ok = !store || entry.write;
        end
        granted = matched && ok;
    end
endmodule

// File: rtl/tlb_first_pick.sv
// Picks the lowest set bit of a request vector and returns its index.
module tlb_first_pick #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest index is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/zone_tlb.sv
// Fully associative, software-loaded TLB with zone protection.
// One registered response per request, one cycle later. Assumes requests
// and writes are sampled on the rising edge; a same-cycle write is not
// seen by the concurrent lookup.
module zone_tlb
    import zone_tlb_pkg::*;
#(
    parameter int          ENTRIES     = 64,
    parameter logic [31:0] ITLB_VECTOR = 32'h0000_1200,
    parameter logic [31:0] DTLB_VECTOR = 32'h0000_1100,
    parameter logic [31:0] STORE_SYND  = 32'h0080_0000,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [SHIFT_W-1:0]   wr_shift,
    input  logic [ADDR_W-1:0]    wr_epn,
    input  logic [TLB_PID_W-1:0] wr_pid,
    input  logic [ADDR_W-1:0]    wr_rpn,
    input  logic                 wr_exec,
    input  logic                 wr_write,
    input  logic [ZONE_W-1:0]    wr_zone,
    input  logic [TLB_PID_W-1:0] cur_pid,
    input  logic [ADDR_W-1:0]    zone_prot,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_store,
    input  logic                 req_fetch,
    input  logic                 req_user,
    input  logic [31:0]          req_msr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [IDX_W-1:0]     rsp_idx,
    output logic [ADDR_W-1:0]    rsp_raddr,
    output logic [1:0]           rsp_perm,
    output logic [1:0]           rsp_fault,
    output logic [ADDR_W-1:0]    rsp_dear,
    output logic [31:0]          rsp_syndrome,
    output logic [31:0]          rsp_vector,
    output logic [31:0]          rsp_msr
);
    tlb_entry_t                 wr_entry;
    tlb_entry_t [ENTRIES-1:0]   entries;
    logic       [ENTRIES-1:0]   match_v;
    logic       [ENTRIES-1:0]   grant_v;
    logic       [1:0]           perm_v [ENTRIES];
    logic                       any_grant;
    logic       [IDX_W-1:0]     win_idx;
    tlb_entry_t                 win;
    logic       [ADDR_W-1:0]    win_mask;
    logic                       is_miss;

    // Pack the software write fields into one entry.
    always_comb begin
        wr_entry = '{valid: wr_valid, shift: wr_shift, epn: wr_epn, pid: wr_pid,
                     rpn: wr_rpn, exec: wr_exec, write: wr_write, zone: wr_zone};
    end

    tlb_entry_file #(.ENTRIES(ENTRIES)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        tlb_entry_check u_chk (
            .entry     (entries[g]),
            .addr      (req_addr),
            .cur_pid   (cur_pid),
            .zone_prot (zone_prot),
            .store     (req_store),
            .fetch     (req_fetch),
            .user      (req_user),
            .matched   (match_v[g]),
            .granted   (grant_v[g]),
            .perm      (perm_v[g])
        );
    end

    tlb_first_pick #(.N(ENTRIES)) u_pick (
        .req   (grant_v),
        .found (any_grant),
        .idx   (win_idx)
    );

    // Select the winning entry and classify the outcome.
    always_comb begin
        win      = entries[win_idx];
        win_mask = page_mask(win.shift);
        is_miss  = !any_grant && !(|match_v);
    end

    // Register the response for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_idx      <= '0;
            rsp_raddr    <= '0;
            rsp_perm     <= '0;
            rsp_fault    <= FLT_NONE;
            rsp_dear     <= '0;
            rsp_syndrome <= '0;
            rsp_vector   <= '0;
            rsp_msr      <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit      <= any_grant;
                rsp_idx      <= any_grant ? win_idx : '0;
                rsp_raddr    <= any_grant ? ((win.rpn & win_mask) | (req_addr & ~win_mask)) : '0;
                rsp_perm     <= any_grant ? perm_v[win_idx] : 2'b00;
                rsp_fault    <= any_grant ? FLT_NONE : (is_miss ? FLT_MISS : FLT_PROT);
                rsp_dear     <= is_miss ? req_addr : '0;
                rsp_syndrome <= (is_miss && !req_fetch && req_store) ? STORE_SYND : '0;
                rsp_vector   <= is_miss ? (req_fetch ? ITLB_VECTOR : DTLB_VECTOR) : '0;
                rsp_msr      <= is_miss ? {16'h0000, req_msr[15:0]} : req_msr;
            end
        end
    end
endmodule

// File: rtl/zone_tlb_chk.sv
// Protocol and response-consistency checker for zone_tlb, bound below.
// Observes ports only.
module zone_tlb_chk #(
    parameter logic [31:0] ITLB_VECTOR = 32'h0000_1200,
    parameter logic [31:0] DTLB_VECTOR = 32'h0000_1100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_fetch,
    input logic [31:0] req_msr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [1:0]  rsp_perm,
    input logic [1:0]  rsp_fault,
    input logic [31:0] rsp_dear,
    input logic [31:0] rsp_syndrome,
    input logic [31:0] rsp_vector,
    input logic [31:0] rsp_msr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_fault == 2'd0 && rsp_perm[0])); // R9
    AST_NOHIT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == 2'b00 && rsp_fault != 2'd0)); // R9
    AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault != 2'd2 || rsp_dear == $past(req_addr))); // R10
    AST_MISS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault != 2'd2 ||
                       rsp_vector == ($past(req_fetch) ? ITLB_VECTOR : DTLB_VECTOR))); // R10
    AST_FETCH_SYND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> rsp_syndrome == 32'h0); // R10
    AST_NOMISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd2) |->
            (rsp_dear == 32'h0 && rsp_syndrome == 32'h0 && rsp_vector == 32'h0)); // R10
    AST_MSR_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault == 2'd2 ? rsp_msr == {16'h0000, $past(req_msr[15:0])}
                                         : rsp_msr == $past(req_msr))); // R11
endmodule

bind zone_tlb zone_tlb_chk #(
    .ITLB_VECTOR (ITLB_VECTOR),
    .DTLB_VECTOR (DTLB_VECTOR)
) u_zone_tlb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_fetch    (req_fetch),
    .req_msr      (req_msr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_perm     (rsp_perm),
    .rsp_fault    (rsp_fault),
    .rsp_dear     (rsp_dear),
    .rsp_syndrome (rsp_syndrome),
    .rsp_vector   (rsp_vector),
    .rsp_msr      (rsp_msr)
);

// File: tb/zone_tlb_tb.sv
`timescale 1ns/1ps
// Directed bench for zone_tlb: one task per scenario, each self-checking.
module zone_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_shift = '0;
    logic [31:0] wr_epn = '0;
    logic [7:0]  wr_pid = '0;
    logic [31:0] wr_rpn = '0;
    logic        wr_exec = 1'b0;
    logic        wr_write = 1'b0;
    logic [3:0]  wr_zone = '0;
    logic [7:0]  cur_pid = 8'd5;
    logic [31:0] zone_prot = 32'h5555_5555;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_store = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] req_msr = '0;
    logic        rsp_valid, rsp_hit;
    logic [5:0]  rsp_idx;
    logic [31:0] rsp_raddr, rsp_dear, rsp_syndrome, rsp_vector, rsp_msr;
    logic [1:0]  rsp_perm, rsp_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    zone_tlb u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic load(input int idx, input bit v, input int sh, input logic [31:0] epn,
                        input logic [7:0] pid, input logic [31:0] rpn,
                        input bit ex, input bit wr, input logic [3:0] zn);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_shift = 5'(sh);
        wr_epn = epn; wr_pid = pid; wr_rpn = rpn; wr_exec = ex; wr_write = wr; wr_zone = zn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one lookup; returns at the negedge where the response is held.
    task automatic lookup(input logic [31:0] a, input bit st, input bit fe,
                          input bit us, input logic [31:0] msr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_store = st; req_fetch = fe;
        req_user = us; req_msr = msr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input int idx,
                              input logic [31:0] ra, input logic [1:0] pm);
        chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(req, "rsp_hit", 32'(rsp_hit), 32'd1);
        chk(req, "rsp_idx", 32'(rsp_idx), 32'(idx));
        chk(req, "rsp_raddr", rsp_raddr, ra);
        chk(req, "rsp_perm", 32'(rsp_perm), 32'(pm));
        chk(req, "rsp_fault", 32'(rsp_fault), 32'd0);
    endtask

    task automatic expect_fault(input string req, input logic [1:0] fc);
        chk(req, "rsp_hit", 32'(rsp_hit), 32'd0);
        chk(req, "rsp_perm", 32'(rsp_perm), 32'd0);
        chk(req, "rsp_fault", 32'(rsp_fault), 32'(fc));
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        lookup(32'h1000_0000, 1'b0, 1'b0, 1'b0, 32'h0);
        expect_fault("R1", 2'd2);
    endtask

    task automatic t_basic();
        load(0, 1, 12, 32'h1000_0000, 8'd0, 32'h8000_0000, 1, 1, 4'd0);
        lookup(32'h1000_0ABC, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        expect_hit("R3", 0, 32'h8000_0ABC, 2'b11);
        chk("R11", "rsp_msr on hit", rsp_msr, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R2", "rsp_valid one cycle only", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_size_and_miss();
        load(1, 1, 20, 32'h2000_0000, 8'd5, 32'h4012_3000, 0, 0, 4'd1);
        lookup(32'h200A_BCDE, 1'b0, 1'b0, 1'b1, 32'h0);
        expect_hit("R5", 1, 32'h401A_BCDE, 2'b01);
        lookup(32'h2010_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_1234);
        expect_fault("R3", 2'd2);
        chk("R10", "dear load miss", rsp_dear, 32'h2010_0000);
        chk("R10", "syndrome load miss", rsp_syndrome, 32'h0);
        chk("R10", "vector data miss", rsp_vector, 32'h0000_1100);
        chk("R11", "msr on miss", rsp_msr, 32'h0000_1234);
        lookup(32'h2010_0000, 1'b1, 1'b0, 1'b0, 32'h0);
        chk("R10", "syndrome store miss", rsp_syndrome, 32'h0080_0000);
        lookup(32'h2010_0000, 1'b1, 1'b1, 1'b0, 32'h0);
        chk("R10", "syndrome fetch miss", rsp_syndrome, 32'h0);
        chk("R10", "vector fetch miss", rsp_vector, 32'h0000_1200);
    endtask

    task automatic t_pid();
        cur_pid = 8'd6;
        lookup(32'h200A_BCDE, 1'b0, 1'b0, 1'b0, 32'h0);
        expect_fault("R4", 2'd2);
        lookup(32'h1000_0004, 1'b0, 1'b0, 1'b0, 32'h0);
        expect_hit("R4", 0, 32'h8000_0004, 2'b11);
        cur_pid = 8'd5;
    endtask

    task automatic t_perm();
        lookup(32'h200A_BCDE, 1'b1, 1'b0, 1'b0, 32'hFFFF_0000);
        expect_fault("R8", 2'd1);
        chk("R10", "dear zero on protection fault", rsp_dear, 32'h0);
        chk("R10", "vector zero on protection fault", rsp_vector, 32'h0);
        chk("R11", "msr kept on protection fault", rsp_msr, 32'hFFFF_0000);
        lookup(32'h200A_BCDE, 1'b0, 1'b1, 1'b0, 32'h0);
        expect_fault("R8", 2'd1);
    endtask

    task automatic t_zone3();
        zone_prot = 32'h7555_5555;
        lookup(32'h200A_BCDE, 1'b1, 1'b0, 1'b1, 32'h0);
        expect_hit("R6", 1, 32'h401A_BCDE, 2'b11);
        lookup(32'h200A_BCDE, 1'b0, 1'b1, 1'b1, 32'h0);
        expect_hit("R6", 1, 32'h401A_BCDE, 2'b11);
    endtask

    task automatic t_zone0();
        zone_prot = 32'h4555_5555;
        lookup(32'h200A_BCDE, 1'b0, 1'b0, 1'b1, 32'h0);
        expect_fault("R7", 2'd1);
        lookup(32'h200A_BCDE, 1'b0, 1'b0, 1'b0, 32'h0);
        expect_hit("R7", 1, 32'h401A_BCDE, 2'b01);
        lookup(32'h200A_BCDE, 1'b1, 1'b0, 1'b0, 32'h0);
        expect_fault("R7", 2'd1);
        zone_prot = 32'h5555_5555;
    endtask

    task automatic t_order();
        load(2, 1, 12, 32'h3000_0000, 8'd0, 32'h0A00_0000, 0, 0, 4'd2);
        load(3, 1, 12, 32'h3000_0000, 8'd0, 32'h0B00_0000, 1, 1, 4'd2);
        load(4, 1, 12, 32'h3000_0000, 8'd0, 32'h0C00_0000, 1, 1, 4'd2);
        lookup(32'h3000_0010, 1'b1, 1'b0, 1'b0, 32'h0);
        expect_hit("R9", 3, 32'h0B00_0010, 2'b11);
        lookup(32'h3000_0010, 1'b0, 1'b0, 1'b0, 32'h0);
        expect_hit("R9", 2, 32'h0A00_0010, 2'b01);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd3; wr_valid = 1'b0;
        req_valid = 1'b1; req_addr = 32'h3000_0010; req_store = 1'b1;
        req_fetch = 1'b0; req_user = 1'b0; req_msr = 32'h0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_hit("R3", 3, 32'h0B00_0010, 2'b11);
        lookup(32'h3000_0010, 1'b1, 1'b0, 1'b0, 32'h0);
        expect_hit("R3", 4, 32'h0C00_0010, 2'b11);
    endtask

    task automatic t_last();
        load(63, 1, 12, 32'h5000_0000, 8'd5, 32'h6000_0000, 1, 0, 4'd3);
        lookup(32'h5000_0FFC, 1'b0, 1'b1, 1'b1, 32'h0);
        expect_hit("R9", 63, 32'h6000_0FFC, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_size_and_miss();
        t_pid();
        t_perm();
        t_zone3();
        t_zone0();
        t_order();
        t_write_timing();
        t_last();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule